// File: doc/BRIEF.md
# Root Port Error and PME Signaling Control

This block holds the root-port control word that decides which error reports turn into a system-error indication and whether power-management-event messages raise an interrupt. Error pulses come in three severities (correctable, non-fatal uncorrectable, fatal). Each severity has two sources: the port's own detection logic and error messages received from devices below the port. A pulse of a severity whose enable is set produces a one-cycle system-error pulse. These enables act on their own. The general system-error enable of the command register plays no part here and cannot mask them.

PME handling is a three-state machine. The states are `PME_IDLE` (no status pending), `PME_MASKED` (status pending, interrupt enable clear) and `PME_ARMED` (status pending, interrupt enable set, interrupt already issued). The transitions work as follows:
- A message moves IDLE to MASKED or to ARMED, depending on the enable.
- Raising the enable moves MASKED to ARMED and issues the interrupt that was held back.
- Clearing the enable moves ARMED to MASKED.
- A clear strobe with no message in the same cycle returns MASKED or ARMED to IDLE.
- A message in ARMED with the enable kept set stays in ARMED and issues one more interrupt.

Software reaches the control word through a small configuration read/write port.

Top module: `rp_err_pme_ctl`

## Requirements
- R1: After reset the control word reads 0000h, `pme_status` is 0, and `serr_pulse` and `pme_irq` are 0.
- R2: The control word lives at configuration offset BCh. Bits 3:0 hold the enables and can be read and written. Bits 15:4 always read 0 and writes to them are ignored. Reads of any other offset return 0, and writes to any other offset leave the word unchanged. Read data follows `cfg_addr` in the same cycle.
- R3: A write with `cfg_we` high takes effect at the clock edge that samples it. It is visible on `cfg_rdata` from the next cycle.
- R4: `serr_pulse` is high in the cycle after a cycle in which any severity pulse (local or message) arrives with its enable set. The severities map to the bits as follows: correctable is bit 0, non-fatal is bit 1, fatal is bit 2. The enables used are the control word as it stood before that cycle's write. Otherwise `serr_pulse` is 0.
- R5: `cmd_serr_en` has no effect on `serr_pulse`. An enabled error still signals when it is 0, and a disabled error stays silent when it is 1.
- R6: A PME message pulse sets `pme_status` in the next cycle, whatever the value of bit 3.
- R7: A `pme_clr` pulse clears `pme_status` in the next cycle. If a PME message arrives in the same cycle, the message wins and the status stays set.
- R8: `pme_irq` pulses for one cycle after a cycle in which a PME message arrives while bit 3, as it stands after that cycle's write, is 1.
- R9: If bit 3 goes from 0 to 1 while `pme_status` is set, and no clear without a message happens in that cycle, `pme_irq` pulses in the next cycle.
- R10: A message that arrives while bit 3 is 0 produces no interrupt. While bit 3 stays 1 and no new message arrives, no further interrupt is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` |
| cmd_serr_en | input | 1 | Command-register system-error enable (ignored) |
| err_local | input | 3 | Locally detected error pulses: bit 0 correctable, bit 1 non-fatal, bit 2 fatal |
| err_msg | input | 3 | Received error message pulses, same bit order as `err_local` |
| pme_msg | input | 1 | Received PME message pulse |
| pme_clr | input | 1 | Write-1-to-clear strobe for PME status |
| pme_status | output | 1 | PME status pending |
| serr_pulse | output | 1 | One-cycle system-error indication |
| pme_irq | output | 1 | One-cycle PME interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, the word at BCh, three severities and a 16-bit data path. The 8-bit offset is small enough to sweep every one of the 256 addresses, so the bench checks that writes and reads decode only at BCh. With three severities and two sources each, random stimulus covers every pattern of simultaneous pulses against every enable combination. The random runs also hit enable toggles that coincide with messages and clears, which are the cases that separate the ARMED and MASKED transitions.

// File: rtl/rp_err_pme_pkg.sv
package rp_err_pme_pkg;
    localparam int SEV_CORR  = 0;
    localparam int SEV_NFAT  = 1;
    localparam int SEV_FATAL = 2;
    localparam int PME_EN_BIT = 3;

    typedef enum logic [1:0] {
        PME_IDLE   = 2'd0,
        PME_MASKED = 2'd1,
        PME_ARMED  = 2'd2
    } pme_state_e;
endpackage

// File: rtl/rp_ctl_word.sv
module rp_ctl_word #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int EN_W    = 4,
    parameter logic [ADDR_W-1:0] REG_OFS = 'hBC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [EN_W-1:0]   en_q,
    output logic [EN_W-1:0]   en_next
);
    localparam int RSVD_W = DATA_W - EN_W;

    logic hit;
    logic past_valid;

    assign hit = (cfg_addr == REG_OFS);

    always_comb begin
        en_next = en_q;
        if (cfg_we && hit) begin
            en_next = cfg_wdata[EN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            past_valid <= 1'b0;
        end else begin
            en_q       <= en_next;
            past_valid <= 1'b1;
        end
    end

    assign cfg_rdata = hit ? {{RSVD_W{1'b0}}, en_q} : '0;

    // R3: a decoded write lands in the enables at the sampling edge
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(cfg_we && hit) |-> en_q == $past(cfg_wdata[EN_W-1:0]));

    // R2: a write elsewhere leaves the enables alone
    p_miss_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(!hit) |-> en_q == $past(en_q));
endmodule

// File: rtl/rp_serr_gate.sv
module rp_serr_gate #(
    parameter int NUM_SEV = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEV-1:0] err_local,
    input  logic [NUM_SEV-1:0] err_msg,
    input  logic [NUM_SEV-1:0] sev_en,
    output logic               serr_pulse
);
    logic [NUM_SEV-1:0] sev_hit;
    logic               past_valid;

    for (genvar s = 0; s < NUM_SEV; s++) begin : g_sev
        assign sev_hit[s] = (err_local[s] | err_msg[s]) & sev_en[s];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serr_pulse <= 1'b0;
            past_valid <= 1'b0;
        end else begin
            serr_pulse <= |sev_hit;
            past_valid <= 1'b1;
        end
    end

    // R4: an enabled severity pulse raises the system-error pulse one cycle later
    p_serr_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(|((err_local | err_msg) & sev_en)) |-> serr_pulse);

    // R4: no enabled pulse, no system error
    p_serr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(((err_local | err_msg) & sev_en) == '0) |-> !serr_pulse);
endmodule

// File: rtl/rp_pme_fsm.sv
module rp_pme_fsm
    import rp_err_pme_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pme_msg,
    input  logic pme_clr,
    input  logic en_q,
    input  logic en_next,
    output logic pme_status,
    output logic pme_irq
);
    pme_state_e state_q, state_d;
    logic       irq_d;
    logic       past_valid;

    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        unique case (state_q)
            PME_IDLE: begin
                if (pme_msg) begin
                    state_d = en_next ? PME_ARMED : PME_MASKED;
                    irq_d   = en_next;
                end
            end
            PME_MASKED: begin
                if (pme_clr && !pme_msg) begin
                    state_d = PME_IDLE;
                end else if (en_next) begin
                    state_d = PME_ARMED;
                    irq_d   = 1'b1;
                end
            end
            PME_ARMED: begin
                if (pme_clr && !pme_msg) begin
                    state_d = PME_IDLE;
                end else if (!en_next) begin
                    state_d = PME_MASKED;
                end else if (pme_msg) begin
                    irq_d = 1'b1;
                end
            end
            default: begin
                state_d = PME_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PME_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pme_irq    <= 1'b0;
            past_valid <= 1'b0;
        end else begin
            pme_irq    <= irq_d;
            past_valid <= 1'b1;
        end
    end

    assign pme_status = (state_q != PME_IDLE);

    // R6: a message always leaves status set
    p_msg_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(pme_msg) |-> pme_status);

    // R7: a clear without a message empties status
    p_clr_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(pme_clr && !pme_msg) |-> !pme_status);

    // R8: an interrupt is only issued with status pending
    p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pme_irq |-> pme_status);

    // R10: no interrupt while the enable register is clear
    p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pme_irq |-> en_q);
endmodule

// File: rtl/rp_err_pme_ctl.sv
module rp_err_pme_ctl
    import rp_err_pme_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int NUM_SEV = 3,
    parameter logic [ADDR_W-1:0] REG_OFS = 'hBC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic               cfg_we,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic               cmd_serr_en,
    input  logic [NUM_SEV-1:0] err_local,
    input  logic [NUM_SEV-1:0] err_msg,
    input  logic               pme_msg,
    input  logic               pme_clr,
    output logic               pme_status,
    output logic               serr_pulse,
    output logic               pme_irq
);
    localparam int EN_W = NUM_SEV + 1;

    logic [EN_W-1:0] en_q;
    logic [EN_W-1:0] en_next;
    logic            past_valid;

    rp_ctl_word #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EN_W   (EN_W),
        .REG_OFS(REG_OFS)
    ) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_addr (cfg_addr),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .en_q     (en_q),
        .en_next  (en_next)
    );

    rp_serr_gate #(
        .NUM_SEV(NUM_SEV)
    ) u_serr (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_local (err_local),
        .err_msg   (err_msg),
        .sev_en    (en_q[NUM_SEV-1:0]),
        .serr_pulse(serr_pulse)
    );

    rp_pme_fsm u_pme (
        .clk       (clk),
        .rst_n     (rst_n),
        .pme_msg   (pme_msg),
        .pme_clr   (pme_clr),
        .en_q      (en_q[EN_W-1]),
        .en_next   (en_next[EN_W-1]),
        .pme_status(pme_status),
        .pme_irq   (pme_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_valid <= 1'b0;
        end else begin
            past_valid <= 1'b1;
        end
    end

    // R5: an enabled fatal error signals even with the command enable clear
    p_cmd_no_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(!cmd_serr_en && (err_local[NUM_SEV-1] || err_msg[NUM_SEV-1])
                            && en_q[NUM_SEV-1]) |-> serr_pulse);

    // R5: the command enable never creates a system error by itself
    p_cmd_no_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(cmd_serr_en && en_q[NUM_SEV-1:0] == '0) |-> !serr_pulse);
endmodule

// File: tb/tb_rp_err_pme_ctl.sv
module tb_rp_err_pme_ctl;
    localparam logic [7:0] OFS = 8'hBC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cmd_serr_en = 1'b0;
    logic [2:0]  err_local = '0;
    logic [2:0]  err_msg = '0;
    logic        pme_msg = 1'b0;
    logic        pme_clr = 1'b0;
    logic        pme_status, serr_pulse, pme_irq;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // reference state
    logic [3:0] m_en = '0;
    logic       m_stat = 1'b0;
    logic       m_serr = 1'b0;
    logic       m_irq = 1'b0;

    always #2 clk = ~clk;

    rp_err_pme_ctl dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_serr_en(cmd_serr_en),
        .err_local(err_local), .err_msg(err_msg), .pme_msg(pme_msg),
        .pme_clr(pme_clr), .pme_status(pme_status), .serr_pulse(serr_pulse),
        .pme_irq(pme_irq)
    );

    task automatic check1(input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [15:0] exp_rd;
        exp_rd = (cfg_addr == OFS) ? {12'h000, m_en} : 16'h0000;
        check1("cfg_rdata", cfg_rdata, exp_rd);
        check1("serr_pulse", {15'd0, serr_pulse}, {15'd0, m_serr});
        check1("pme_irq", {15'd0, pme_irq}, {15'd0, m_irq});
        check1("pme_status", {15'd0, pme_status}, {15'd0, m_stat});
    endtask

    // one clock with the inputs currently driven; model update then compare
    task automatic cyc();
        logic [3:0] en_n;
        logic       serr_n, irq_n, stat_n;
        en_n   = (cfg_we && cfg_addr == OFS) ? cfg_wdata[3:0] : m_en;
        serr_n = |((err_local | err_msg) & m_en[2:0]);
        irq_n  = en_n[3] && (pme_msg || (m_stat && !m_en[3] && !pme_clr));
        stat_n = pme_msg || (m_stat && !pme_clr);
        @(posedge clk);
        @(negedge clk);
        m_en = en_n; m_serr = serr_n; m_irq = irq_n; m_stat = stat_n;
        compare();
    endtask

    task automatic idle();
        cfg_we = 0; err_local = '0; err_msg = '0; pme_msg = 0; pme_clr = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1;
        cyc();
        idle();
        cfg_addr = OFS;
    endtask

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cfg_addr = OFS;
        // R1: reset values
        tag = "R1";
        compare();
        cyc();

        // R2 / R3: register decode and reserved bits
        tag = "R2";
        wr(OFS, 16'hFFFF);
        cyc();
        wr(OFS, 16'h0000);
        for (int a = 0; a < 256; a++) begin
            if (a[7:0] != OFS) begin
                cfg_addr = a[7:0];
                cfg_wdata = 16'hFFFF; cfg_we = 1;
                cyc();
            end
        end
        idle(); cfg_addr = OFS; cyc();
        tag = "R3";
        wr(OFS, 16'h000A);
        cyc();

        // R4 / R5: each severity, both sources, command bit both ways
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 2; c++) begin
                cmd_serr_en = c[0];
                tag = "R4";
                wr(OFS, 16'h0001 << s);
                err_local[s] = 1; cyc(); idle();
                err_msg[s] = 1; cyc(); idle();
                tag = "R5";
                wr(OFS, 16'h0000);
                err_local[s] = 1; err_msg[s] = 1; cyc(); idle();
                cyc();
            end
        end
        cmd_serr_en = 0;

        // R6 / R10 / R9: masked message, then enable rise
        tag = "R6";
        wr(OFS, 16'h0000);
        pme_msg = 1; cyc(); idle();
        tag = "R10";
        cyc(); cyc();
        tag = "R9";
        wr(OFS, 16'h0008);
        tag = "R10";
        cyc(); cyc();
        // R7: clear, and clear colliding with a message
        tag = "R7";
        pme_clr = 1; cyc(); idle();
        pme_msg = 1; cyc(); idle();
        pme_clr = 1; pme_msg = 1; cyc(); idle();
        pme_clr = 1; cyc(); idle();
        // R8: enabled messages back to back
        tag = "R8";
        pme_msg = 1; cyc(); cyc(); idle(); cyc();
        // R9: enable rise and message in the same cycle from idle status
        tag = "R9";
        pme_clr = 1; cfg_we = 1; cfg_wdata = 16'h0000; cyc(); idle();
        pme_msg = 1; cfg_we = 1; cfg_wdata = 16'h0008; cyc(); idle();
        wr(OFS, 16'h0000);
        wr(OFS, 16'h0008);

        // mixed random traffic
        tag = "R8";
        for (int i = 0; i < 4000; i++) begin
            cfg_addr    = ($urandom % 4 == 0) ? 8'($urandom) : OFS;
            cfg_we      = ($urandom % 6 == 0);
            cfg_wdata   = 16'($urandom);
            cmd_serr_en = 1'($urandom);
            err_local   = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
            err_msg     = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
            pme_msg     = ($urandom % 5 == 0);
            pme_clr     = ($urandom % 5 == 0);
            cyc();
        end
        idle(); cyc();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule